// File: doc/BRIEF.md
# Palette RAM Address Arbiter

This block sits between a CPU bus, a video pixel stream and an external 4096-entry palette RAM. Each clock it picks the RAM address from one of two sources. A CPU access to the palette region is one source, and the colour index of the current pixel is the other. The CPU always wins and never waits. A pixel fetched while the CPU holds the RAM shows whatever entry the CPU address selects. This brief display glitch is accepted by design.

The 16-bit word that the RAM returns is captured into two 8-bit colour registers that drive a colour DAC. The registers load on a pixel strobe and hold the value until the next strobe. When the pixel being loaded falls in blanking, a zero colour is loaded instead. The block registers the RAM address and the RAM control lines, so the RAM sees stable values for a full clock. The RAM read data is expected back combinationally within that clock.

Top module: `pal_arbiter`

## Requirements
- R1: While `rst_n` is sampled low, the block sets `pal_addr` to 0, `ram_we_n` and `ram_oe_n` to 1, and `color_hi` and `color_lo` to 0.
- R2: When `cpu_sel` is low in a cycle, `pal_addr` equals that cycle's `vid_index` after the next clock edge.
- R3: When `cpu_sel` is high in a cycle, `pal_addr` equals `cpu_addr[11:0]` (CPU address lines A1..A12) after the next clock edge, whatever the value of `vid_index`.
- R4: `cpu_addr` bits above bit 11 have no effect on `pal_addr`.
- R5: `ram_we_n` is 0 in the cycle after a cycle with `cpu_sel` and `cpu_wr` both high, and 1 otherwise.
- R6: `ram_oe_n` is 1 in the cycle after a CPU write cycle and 0 after any other cycle. It is never 0 while `ram_we_n` is 0.
- R7: When `pix_stb` is high in a cycle and `vid_blank` is low, then two clock edges later `color_hi` holds `ram_data[15:8]` and `color_lo` holds `ram_data[7:0]`. The data is the RAM word at the address that `pal_addr` carried after the first edge.
- R8: `color_hi` and `color_lo` keep their value over any edge that does not complete a strobed load.
- R9: When `pix_stb` and `vid_blank` are both high in a cycle, both colour registers hold 0 two clock edges later.
- R10: When a CPU access coincides with a strobed pixel, the colour loaded for that pixel is the RAM entry at the CPU address, not at the pixel's colour index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_sel | input | 1 | CPU access to the palette region this cycle |
| cpu_wr | input | 1 | CPU access is a write |
| cpu_addr | input | 23 | CPU word address, bit 0 is line A1 |
| vid_index | input | 12 | Colour index of the current pixel |
| pix_stb | input | 1 | Pixel strobe: load this pixel's colour |
| vid_blank | input | 1 | Current pixel lies in blanking |
| ram_data | input | 16 | Palette RAM read data |
| pal_addr | output | 12 | Palette RAM address |
| ram_we_n | output | 1 | Palette RAM write enable, active low |
| ram_oe_n | output | 1 | Palette RAM output enable, active low |
| color_hi | output | 8 | Upper colour byte to the DAC |
| color_lo | output | 8 | Lower colour byte to the DAC |

## Verification
The address and both RAM control lines are due one clock edge after the inputs that select them. The colour bytes are due two edges after a strobe, and for that load the RAM data is sampled while the registered address is on the bus. The bench drives each cycle's inputs on the falling edge and compares outputs on the following falling edge. It keeps a one-deep model of the pending colour load, so a strobe issued in one step is expected to show up at the check of the next step. Between strobes, the same model expects the colour to be held unchanged.

// File: rtl/pal_arb_pkg.sv
// Package pal_arb_pkg
// Shared widths and types for the palette address arbiter.
// Assumes a 16-bit palette word split into 8-bit DAC lanes.
package pal_arb_pkg;
    localparam int PAL_AW  = 12;
    localparam int CPU_AW  = 23;
    localparam int WORD_W  = 16;
    localparam int LANE_W  = 8;

    typedef enum logic {
        SRC_VIDEO = 1'b0,
        SRC_CPU   = 1'b1
    } pal_src_e;
endpackage

// File: rtl/pal_src_arb.sv
// Module pal_src_arb
// Chooses the palette RAM address source each cycle, CPU first, and
// registers it together with the pixel strobe and blank flag so they
// stay aligned with the address on the RAM bus.
// Assumes cpu_sel already decodes the palette region; no wait states.
module pal_src_arb
    import pal_arb_pkg::*;
#(
    parameter int P_AW = PAL_AW,
    parameter int C_AW = CPU_AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_sel,
    input  logic [C_AW-1:0] cpu_addr,
    input  logic [P_AW-1:0] vid_index,
    input  logic            pix_stb,
    input  logic            vid_blank,
    output logic [P_AW-1:0] pal_addr,
    output logic            ld_q,
    output logic            blank_q
);

    pal_src_e        src;
    logic [P_AW-1:0] next_addr;
    logic [P_AW-1:0] cpu_word;

    // Palette word index taken from the low CPU address lines only.
    assign cpu_word = cpu_addr[P_AW-1:0];

    // Source selection: a CPU access always takes the bus.
    always_comb begin
        src = cpu_sel ? SRC_CPU : SRC_VIDEO;
        case (src)
            SRC_CPU:   next_addr = cpu_word;
            default:   next_addr = vid_index;
        endcase
    end

    // Register address and the pixel qualifiers that travel with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pal_addr <= '0;
            ld_q     <= 1'b0;
            blank_q  <= 1'b0;
        end else begin
            pal_addr <= next_addr;
            ld_q     <= pix_stb;
            blank_q  <= vid_blank;
        end
    end

    assert_cpu_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cpu_sel)) |-> (pal_addr == $past(cpu_addr[P_AW-1:0])));

    assert_video_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cpu_sel)) |-> (pal_addr == $past(vid_index)));

endmodule

// File: rtl/pal_ram_ctrl.sv
// Module pal_ram_ctrl
// Generates the palette RAM strobes: write enable for a CPU write,
// output enable for every other cycle (CPU read or video fetch).
// Assumes the RAM needs its controls registered with the address.
module pal_ram_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_sel,
    input  logic cpu_wr,
    output logic ram_we_n,
    output logic ram_oe_n
);

    logic wr_cycle;

    // A write cycle is a selected CPU access with the write flag set.
    assign wr_cycle = cpu_sel & cpu_wr;

    // Register active-low strobes; both idle high in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we_n <= 1'b1;
            ram_oe_n <= 1'b1;
        end else begin
            ram_we_n <= ~wr_cycle;
            ram_oe_n <= wr_cycle;
        end
    end

    assert_we_follows_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ram_we_n == !($past(cpu_sel) && $past(cpu_wr))));

    assert_no_bus_fight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we_n || ram_oe_n));

endmodule

// File: rtl/pal_color_latch.sv
// Module pal_color_latch
// Splits the palette word into byte lanes and loads them on a
// qualified pixel strobe; a blanked pixel loads zero.
// Assumes ram_data is valid in the cycle ld_en is high.
module pal_color_latch
    import pal_arb_pkg::*;
#(
    parameter int D_W = WORD_W,
    parameter int L_W = LANE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_en,
    input  logic           blank,
    input  logic [D_W-1:0] ram_data,
    output logic [D_W-1:0] color
);

    localparam int LANES = D_W / L_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // One byte register per DAC lane, load-enabled by the strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                color[g*L_W +: L_W] <= '0;
            end else if (ld_en) begin
                color[g*L_W +: L_W] <= blank ? '0 : ram_data[g*L_W +: L_W];
            end
        end
    end

    assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ld_en)) |-> $stable(color));

    assert_blank_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_en) && $past(blank)) |-> (color == '0));

endmodule

// File: rtl/pal_arbiter.sv
// Module pal_arbiter
// Top level: palette RAM address arbitration between CPU and video,
// RAM strobes, and the two DAC colour registers.
// Assumes an asynchronous-read RAM answering within one clock.
module pal_arbiter
    import pal_arb_pkg::*;
#(
    parameter int P_AW = PAL_AW,
    parameter int C_AW = CPU_AW,
    parameter int D_W  = WORD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_sel,
    input  logic            cpu_wr,
    input  logic [C_AW-1:0] cpu_addr,
    input  logic [P_AW-1:0] vid_index,
    input  logic            pix_stb,
    input  logic            vid_blank,
    input  logic [D_W-1:0]  ram_data,
    output logic [P_AW-1:0] pal_addr,
    output logic            ram_we_n,
    output logic            ram_oe_n,
    output logic [7:0]      color_hi,
    output logic [7:0]      color_lo
);

    logic           ld_q;
    logic           blank_q;
    logic [D_W-1:0] color;

    pal_src_arb #(.P_AW(P_AW), .C_AW(C_AW)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_sel   (cpu_sel),
        .cpu_addr  (cpu_addr),
        .vid_index (vid_index),
        .pix_stb   (pix_stb),
        .vid_blank (vid_blank),
        .pal_addr  (pal_addr),
        .ld_q      (ld_q),
        .blank_q   (blank_q)
    );

    pal_ram_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_sel  (cpu_sel),
        .cpu_wr   (cpu_wr),
        .ram_we_n (ram_we_n),
        .ram_oe_n (ram_oe_n)
    );

    pal_color_latch #(.D_W(D_W), .L_W(8)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_q),
        .blank    (blank_q),
        .ram_data (ram_data),
        .color    (color)
    );

    // Byte lanes to the DAC pins.
    assign color_hi = color[15:8];
    assign color_lo = color[7:0];

endmodule

// File: tb/test_pal_arbiter.sv
module test_pal_arbiter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_sel, cpu_wr, pix_stb, vid_blank;
    logic [22:0] cpu_addr;
    logic [11:0] vid_index;
    logic [15:0] ram_data;
    logic [11:0] pal_addr;
    logic        ram_we_n, ram_oe_n;
    logic [7:0]  color_hi, color_lo;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Expected-state model
    logic [15:0] exp_color;
    logic        pend_ld, pend_blank;
    logic [15:0] pend_val;

    always #2 clk = ~clk;

    // Bench palette content: a fixed hash of the address.
    function automatic logic [15:0] ram_word(input logic [11:0] a);
        logic [31:0] t;
        t = {20'd0, a} * 32'd40503;
        return t[15:0] ^ 16'h5A3C;
    endfunction

    assign ram_data = ram_word(pal_addr);

    pal_arbiter i_pal_arbiter (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .vid_index(vid_index), .pix_stb(pix_stb),
        .vid_blank(vid_blank), .ram_data(ram_data), .pal_addr(pal_addr),
        .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
        .color_hi(color_hi), .color_lo(color_lo)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check at the next falling edge.
    task automatic step(input logic sel, input logic wr, input logic [22:0] ca,
                        input logic [11:0] vi, input logic stb, input logic blk,
                        input string addr_tag);
        logic [11:0] ea;
        string ctag;
        cpu_sel = sel; cpu_wr = wr; cpu_addr = ca;
        vid_index = vi; pix_stb = stb; vid_blank = blk;
        @(posedge clk);
        @(negedge clk);
        ea = sel ? ca[11:0] : vi;
        if (pend_ld) begin
            exp_color = pend_val;
            ctag = pend_blank ? "R9" : "R7";
        end else begin
            ctag = "R8";
        end
        pend_ld = stb;
        pend_blank = blk;
        pend_val = blk ? 16'h0 : ram_word(ea);
        chk(addr_tag, pal_addr, ea);
        chk("R5", ram_we_n, !(sel && wr));
        chk("R6", ram_oe_n, sel && wr);
        chk(ctag, {color_hi, color_lo}, exp_color);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst_n = 1'b0;
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = 23'h7FFFFF;
        vid_index = 12'hABC; pix_stb = 1'b1; vid_blank = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", pal_addr, 0);
        chk("R1", ram_we_n, 1);
        chk("R1", ram_oe_n, 1);
        chk("R1", {color_hi, color_lo}, 0);
        rst_n = 1'b1;
        exp_color = 16'h0; pend_ld = 1'b0; pend_blank = 1'b0; pend_val = 16'h0;

        // Directed: video fetch at both index extremes
        step(0, 0, 23'h0, 12'h000, 1, 0, "R2");
        step(0, 0, 23'h0, 12'hFFF, 1, 0, "R2");
        step(0, 0, 23'h0, 12'h123, 0, 0, "R2");
        // R8 hold over several idle pixels
        step(0, 0, 23'h0, 12'h555, 0, 0, "R2");
        // R4: upper CPU bits all ones, low bits zero
        step(1, 0, 23'h7FF000, 12'h777, 0, 0, "R4");
        step(1, 0, 23'h000FFF, 12'h000, 0, 0, "R3");
        // R10: CPU read coincides with a strobed pixel
        step(1, 0, 23'h3A0456, 12'h123, 1, 0, "R10_addr");
        step(0, 0, 23'h0, 12'h321, 0, 0, "R2");
        chk("R10", {color_hi, color_lo}, ram_word(12'h456));
        // R10 with a CPU write over a strobed pixel
        step(1, 1, 23'h000789, 12'h111, 1, 0, "R3");
        step(0, 0, 23'h0, 12'h222, 0, 0, "R2");
        chk("R10", {color_hi, color_lo}, ram_word(12'h789));
        // R9 blanking over a strobe
        step(0, 0, 23'h0, 12'hFFF, 1, 1, "R2");
        step(0, 0, 23'h0, 12'h001, 1, 0, "R2");
        step(0, 0, 23'h0, 12'h002, 0, 0, "R2");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic s, w, p, b;
            logic [22:0] a;
            logic [11:0] v;
            s = ($urandom % 10) < 3;
            w = $urandom % 2;
            p = $urandom % 2;
            b = ($urandom % 4) == 0;
            a = 23'($urandom);
            v = 12'($urandom);
            step(s, w, a, v, p, b, s ? "R3" : "R2");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule